// File: doc/BRIEF.md
# Clock Activity Failure Monitor

This block watches a low-frequency clock that comes from outside the chip and decides, window by window, whether that clock is still running. A free-running safe reference clock, which also clocks all of the block's decision logic, measures the windows. Each window is four safe-clock periods long. A window passes only if the monitored clock made at least one rising edge and at least one falling edge inside it. Any other window is a failure.

A live status output shows the result of the most recent window, so it clears again once the clock recovers. A separate sticky flag records that a failure has happened until software clears it. The flag drives an interrupt line through an enable. A one-cycle event pulse marks each move into the failed condition. The event is held back while the clock path downstream is already running from the safe source.

Monitoring starts when both the enable bit and the oscillator-enabled input are high. A start-up blanking count, loaded on every entry into monitoring, holds off all verdicts while the oscillator settles. Only the power-on reset clears the block's state.

The controller is a three-state machine:
- `ST_OFF`: idle. The blanking counter follows `startup_cycles`, and the live status is held low.
- `ST_BLANK`: the blanking counter counts down.
- `ST_WATCH`: windows run back to back.

Its transitions are:
- `OFF->BLANK` when the enable bit and the oscillator input are both high.
- `BLANK->WATCH` when the counter reaches zero.
- `BLANK->OFF` and `WATCH->OFF` whenever either the enable bit or the oscillator input goes low.

Top module: `clk_fail_monitor`

## Requirements
- R1: A window of 4 safe-clock cycles that contains at least one rising and one falling monitored-clock edge leaves `fail_status` low and does not set `fail_flag`.
- R2: A window that contains no monitored-clock edge, or only rising edges, or only falling edges, drives `fail_status` high at the end of that window.
- R3: While the controller is in `ST_OFF`, the blanking counter holds `startup_cycles`. When `mon_en` and `osc_on` are both first sampled high at a safe-clock edge (edge 1), the first verdict is registered at edge `startup_cycles + 6`. No verdict is registered before that edge.
- R4: While `osc_on` or `mon_en` is low, no windows run. `fail_status` is forced low from the second edge onwards, and neither `fail_flag` nor `fail_evt` is set.
- R5: `fail_status` reflects only the most recent window, so it returns low once a window passes after a failure.
- R6: Every failing window sets `fail_flag`. The flag stays high until a cycle in which `flag_clr` is high and no failing verdict is registered; a failing verdict in the same cycle wins over the clear.
- R7: `irq` is high exactly when `fail_flag` and `irq_en` are both high.
- R8: `fail_evt` is a single safe-clock pulse. It appears in the same cycle that `fail_status` goes from low to high, and only if `evt_en` is high and `on_safe_src` is low at that edge. Further failing windows do not repeat it.
- R9: `fail_flag` and all other state are cleared only by `por_n` low. Dropping `mon_en` or `osc_on` leaves the flag as it was.
- R10: Every re-entry into monitoring reloads the blanking count, so each restart meets the full delay of R3 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| safe_clk | input | 1 | Safe reference clock; clocks all decision logic |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mon_clk | input | 1 | Monitored external clock |
| mon_en | input | 1 | Monitor enable bit |
| osc_on | input | 1 | High while the external oscillator is enabled |
| startup_cycles | input | 16 | Blanking length in safe-clock cycles |
| irq_en | input | 1 | Interrupt enable |
| evt_en | input | 1 | Event output enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the sticky flag |
| on_safe_src | input | 1 | High while the clock path already runs from the safe source |
| fail_status | output | 1 | Live result of the last window (1 = failed) |
| fail_flag | output | 1 | Sticky failure flag |
| irq | output | 1 | Interrupt request |
| fail_evt | output | 1 | One-cycle failure event |

## Verification
The bench sweeps several blanking lengths with a dead clock and counts edges up to the first verdict. A counter that is off by one, or one that is not reloaded on restart, shifts that count. A sparse clock, slow enough that each window holds only one edge, separates a design that wants both edge kinds from one that accepts any activity. A clock that recovers after a failure must bring the live status back down while the sticky flag stays up. A block that merges status and flag, or that clears the flag on disable, fails there. The event is counted across long failing stretches, with the safe-source input both high and low, to catch repeated pulses or a missing suppression.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_BLANK = 2'd1,
        ST_WATCH = 2'd2
    } cfm_state_e;

endpackage

// File: rtl/cfm_edge_sync.sv
// Toggles a flag on one kind of monitored-clock edge, carries it into the
// safe domain through two flip-flops and flags every observed change.
module cfm_edge_sync #(
    parameter bit FALLING = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic safe_clk,
    input  logic por_n,
    output logic edge_seen
);
    localparam int CHAIN = SYNC_STAGES + 1;

    logic             tgl;
    logic [CHAIN-1:0] chain;

    generate
        if (FALLING) begin : g_fall
            always_ff @(negedge mon_clk or negedge por_n) begin
                if (!por_n) tgl <= 1'b0;
                else        tgl <= ~tgl;
            end
        end else begin : g_rise
            always_ff @(posedge mon_clk or negedge por_n) begin
                if (!por_n) tgl <= 1'b0;
                else        tgl <= ~tgl;
            end
        end
    endgenerate

    always_ff @(posedge safe_clk or negedge por_n) begin
        if (!por_n) chain <= '0;
        else        chain <= {chain[CHAIN-2:0], tgl};
    end

    assign edge_seen = chain[CHAIN-1] ^ chain[CHAIN-2];

endmodule

// File: rtl/cfm_window.sv
// Runs back-to-back windows of WIN_LEN safe cycles while run is high and
// reports a verdict in the last cycle of each window.
module cfm_window #(
    parameter int WIN_LEN = 4
) (
    input  logic safe_clk,
    input  logic por_n,
    input  logic run,
    input  logic rise_seen,
    input  logic fall_seen,
    output logic verdict_vld,
    output logic verdict_ok
);
    localparam int CW = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(WIN_LEN - 1);

    logic [CW-1:0] cnt;
    logic          got_rise;
    logic          got_fall;

    assign verdict_vld = run && (cnt == LAST);
    assign verdict_ok  = (got_rise || rise_seen) && (got_fall || fall_seen);

    always_ff @(posedge safe_clk or negedge por_n) begin
        if (!por_n) begin
            cnt      <= '0;
            got_rise <= 1'b0;
            got_fall <= 1'b0;
        end else if (!run || verdict_vld) begin
            cnt      <= '0;
            got_rise <= 1'b0;
            got_fall <= 1'b0;
        end else begin
            cnt      <= cnt + 1'b1;
            got_rise <= got_rise || rise_seen;
            got_fall <= got_fall || fall_seen;
        end
    end

endmodule

// File: rtl/clk_fail_monitor.sv
module clk_fail_monitor #(
    parameter int BLANK_W = 16,
    parameter int WIN_LEN = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               safe_clk,
    input  logic               por_n,
    input  logic               mon_clk,
    input  logic               mon_en,
    input  logic               osc_on,
    input  logic [BLANK_W-1:0] startup_cycles,
    input  logic               irq_en,
    input  logic               evt_en,
    input  logic               flag_clr,
    input  logic               on_safe_src,
    output logic               fail_status,
    output logic               fail_flag,
    output logic               irq,
    output logic               fail_evt
);
    import cfm_pkg::*;

    cfm_state_e         state;
    cfm_state_e         state_nx;
    logic [BLANK_W-1:0] blank_cnt;
    logic               active;
    logic               rise_seen;
    logic               fall_seen;
    logic               verdict_vld;
    logic               verdict_ok;
    logic               bad_window;

    assign active = mon_en && osc_on;

    cfm_edge_sync #(.FALLING(1'b0), .SYNC_STAGES(SYNC_STAGES)) u_rise (
        .mon_clk  (mon_clk),
        .safe_clk (safe_clk),
        .por_n    (por_n),
        .edge_seen(rise_seen)
    );

    cfm_edge_sync #(.FALLING(1'b1), .SYNC_STAGES(SYNC_STAGES)) u_fall (
        .mon_clk  (mon_clk),
        .safe_clk (safe_clk),
        .por_n    (por_n),
        .edge_seen(fall_seen)
    );

    cfm_window #(.WIN_LEN(WIN_LEN)) u_win (
        .safe_clk   (safe_clk),
        .por_n      (por_n),
        .run        (state == ST_WATCH),
        .rise_seen  (rise_seen),
        .fall_seen  (fall_seen),
        .verdict_vld(verdict_vld),
        .verdict_ok (verdict_ok)
    );

    assign bad_window = verdict_vld && !verdict_ok;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF:   if (active) state_nx = ST_BLANK;
            ST_BLANK: begin
                if (!active)              state_nx = ST_OFF;
                else if (blank_cnt == '0) state_nx = ST_WATCH;
            end
            ST_WATCH: if (!active) state_nx = ST_OFF;
            default:  state_nx = ST_OFF;
        endcase
    end

    // state register and blanking counter
    always_ff @(posedge safe_clk or negedge por_n) begin
        if (!por_n) begin
            state     <= ST_OFF;
            blank_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_OFF)
                blank_cnt <= startup_cycles;
            else if (state == ST_BLANK && blank_cnt != '0)
                blank_cnt <= blank_cnt - 1'b1;
        end
    end

    // outputs
    always_ff @(posedge safe_clk or negedge por_n) begin
        if (!por_n) begin
            fail_status <= 1'b0;
            fail_flag   <= 1'b0;
            fail_evt    <= 1'b0;
        end else begin
            fail_evt <= bad_window && !fail_status && evt_en && !on_safe_src;
            unique case (state)
                ST_OFF:   fail_status <= 1'b0;
                ST_BLANK: fail_status <= fail_status;
                ST_WATCH: if (verdict_vld) fail_status <= !verdict_ok;
                default:  fail_status <= 1'b0;
            endcase
            if (bad_window)    fail_flag <= 1'b1;
            else if (flag_clr) fail_flag <= 1'b0;
        end
    end

    assign irq = fail_flag && irq_en;

endmodule

// File: rtl/cfm_checker.sv
module cfm_checker (
    input logic safe_clk,
    input logic por_n,
    input logic osc_on,
    input logic mon_en,
    input logic evt_en,
    input logic on_safe_src,
    input logic flag_clr,
    input logic fail_status,
    input logic fail_flag,
    input logic irq,
    input logic fail_evt
);
    assert_evt_single_R8: assert property (@(posedge safe_clk) disable iff (!por_n)
        fail_evt |=> !fail_evt);

    assert_evt_gate_R8: assert property (@(posedge safe_clk) disable iff (!por_n)
        fail_evt |-> ($past(evt_en) && !$past(on_safe_src) && fail_status && fail_flag));

    assert_off_quiet_R4: assert property (@(posedge safe_clk) disable iff (!por_n)
        (!(osc_on && mon_en) && $past(!(osc_on && mon_en)) && $past(!(osc_on && mon_en), 2))
        |-> !fail_status);

    assert_flag_sticky_R6: assert property (@(posedge safe_clk) disable iff (!por_n)
        ($past(fail_flag) && !$past(flag_clr)) |-> fail_flag);

    assert_flag_on_fail_R6: assert property (@(posedge safe_clk) disable iff (!por_n)
        $rose(fail_status) |-> fail_flag);

    assert_irq_needs_flag_R7: assert property (@(posedge safe_clk) disable iff (!por_n)
        irq |-> fail_flag);

endmodule

bind clk_fail_monitor cfm_checker u_cfm_checker (
    .safe_clk   (safe_clk),
    .por_n      (por_n),
    .osc_on     (osc_on),
    .mon_en     (mon_en),
    .evt_en     (evt_en),
    .on_safe_src(on_safe_src),
    .flag_clr   (flag_clr),
    .fail_status(fail_status),
    .fail_flag  (fail_flag),
    .irq        (irq),
    .fail_evt   (fail_evt)
);

// File: tb/clk_fail_monitor_bench.sv
`timescale 1ns/1ps
module clk_fail_monitor_bench;
    logic        safe_clk = 1'b0;
    logic        por_n = 1'b0;
    logic        mon_clk = 1'b0;
    logic        mon_en = 1'b0;
    logic        osc_on = 1'b0;
    logic [15:0] startup_cycles = '0;
    logic        irq_en = 1'b0;
    logic        evt_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        on_safe_src = 1'b0;
    logic        fail_status, fail_flag, irq, fail_evt;

    int n_chk = 0;
    int n_bad = 0;
    int mode = 0; // 0 dead low, 2 live (24 ns period), 3 sparse (96 ns period)

    clk_fail_monitor u_clk_fail_monitor (
        .safe_clk(safe_clk), .por_n(por_n), .mon_clk(mon_clk), .mon_en(mon_en),
        .osc_on(osc_on), .startup_cycles(startup_cycles), .irq_en(irq_en),
        .evt_en(evt_en), .flag_clr(flag_clr), .on_safe_src(on_safe_src),
        .fail_status(fail_status), .fail_flag(fail_flag), .irq(irq), .fail_evt(fail_evt)
    );

    always #4 safe_clk = ~safe_clk;

    initial begin
        forever begin
            if (mode == 2)      begin #12; mon_clk = ~mon_clk; end
            else if (mode == 3) begin #48; mon_clk = ~mon_clk; end
            else                begin mon_clk = 1'b0; #4; end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge safe_clk);
    endtask

    // count event pulses and highest status over n cycles
    task automatic watch(input int n, output int evts, output int st_hi, output int st_lo);
        evts = 0; st_hi = 0; st_lo = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge safe_clk);
            if (fail_evt) evts++;
            if (fail_status) st_hi++; else st_lo++;
        end
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1; cyc(1); flag_clr = 1'b0;
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int k, e, hi, lo;
        int sweep [5] = '{0, 1, 4, 13, 40};
        cyc(5);
        check("R9 reset status", fail_status, 0);
        check("R9 reset flag", fail_flag, 0);
        check("R9 reset irq", irq, 0);
        check("R9 reset evt", fail_evt, 0);
        por_n = 1'b1;
        cyc(2);
        irq_en = 1'b1; evt_en = 1'b1;

        // R3/R10: blanking sweep with a dead clock, restarted each time
        foreach (sweep[s]) begin
            mode = 0; mon_en = 1'b0; osc_on = 1'b0;
            cyc(3);
            clear_flag();
            startup_cycles = 16'(sweep[s]);
            cyc(1);
            mon_en = 1'b1; osc_on = 1'b1;
            k = 0;
            for (int i = 0; i < 200; i++) begin
                @(posedge safe_clk); k++;
                @(negedge safe_clk);
                if (fail_status) break;
            end
            check("R3 R10 first verdict edge", k, sweep[s] + 6);
            check("R2 dead clock status", fail_status, 1);
            check("R6 flag set", fail_flag, 1);
            check("R7 irq", irq, 1);
            check("R8 event on transition", fail_evt, 1);
            watch(30, e, hi, lo);
            check("R8 no repeat event", e, 0);
            check("R2 stays failed", lo, 0);
        end

        // R1/R5: recovery with a live clock
        mode = 2;
        cyc(20);
        watch(40, e, hi, lo);
        check("R5 status recovers", hi, 0);
        check("R6 flag sticky after recovery", fail_flag, 1);
        clear_flag();
        check("R6 flag cleared", fail_flag, 0);
        check("R7 irq follows flag", irq, 0);
        watch(60, e, hi, lo);
        check("R1 live clock passes", hi, 0);
        check("R1 no flag on live clock", fail_flag, 0);

        // R2: one edge kind per window
        mode = 3;
        cyc(30);
        watch(60, e, hi, lo);
        check("R2 sparse clock fails", lo, 0);
        check("R6 flag on sparse", fail_flag, 1);
        irq_en = 1'b0;
        cyc(1);
        check("R7 irq masked", irq, 0);
        irq_en = 1'b1;

        // R8: suppression while on safe source, and with events disabled
        mode = 2; cyc(30);
        on_safe_src = 1'b1; mode = 0;
        watch(40, e, hi, lo);
        check("R8 no event on safe source", e, 0);
        check("R2 status while on safe source", fail_status, 1);
        on_safe_src = 1'b0; mode = 2; cyc(30);
        mode = 0;
        watch(40, e, hi, lo);
        check("R8 exactly one event", e, 1);
        mode = 2; cyc(30);
        evt_en = 1'b0; mode = 0;
        watch(40, e, hi, lo);
        check("R8 no event when disabled", e, 0);
        evt_en = 1'b1;

        // R6: failing verdict wins over a clear held high
        flag_clr = 1'b1;
        cyc(20);
        check("R6 set wins over clear", fail_flag, 1);
        flag_clr = 1'b0;

        // R4: oscillator off, then enable off
        clear_flag();
        osc_on = 1'b0;
        cyc(3);
        check("R4 status low with oscillator off", fail_status, 0);
        watch(50, e, hi, lo);
        check("R4 no event with oscillator off", e, 0);
        check("R4 no flag with oscillator off", fail_flag, 0);
        osc_on = 1'b1; mon_en = 1'b0;
        cyc(3);
        watch(50, e, hi, lo);
        check("R4 status low with monitor off", hi, 0);
        check("R4 no flag with monitor off", fail_flag, 0);

        // R9: disable keeps the flag, only reset clears it
        startup_cycles = 16'd2;
        mon_en = 1'b1;
        cyc(20);
        check("R9 flag before disable", fail_flag, 1);
        mon_en = 1'b0; osc_on = 1'b0;
        cyc(20);
        check("R9 flag survives disable", fail_flag, 1);
        por_n = 1'b0;
        cyc(2);
        check("R9 reset clears flag", fail_flag, 0);
        por_n = 1'b1;
        cyc(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule